// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which hardware thread of a multithreaded out-of-order core may retire its oldest instruction in the current commit slot. For every thread it receives a status code, a flag saying the oldest instruction is ready, a flag saying that thread's reorder buffer is empty, and the sequence number of that oldest instruction. It returns a valid flag and a thread index. The answer is purely combinational, so the surrounding commit logic can consult it once per commit slot within a single cycle. It can feed each slot's retirement back in before asking again.

A static policy input chooses how the winner is found. In the oldest-first policy, the candidate holding the smallest sequence number wins. The greedy policy is an alias of the oldest-first policy. The rotating policy walks an ordered list of thread indices from its front. The first candidate found wins. When the caller signals that the grant was used, that thread moves to the tail of the list. The other threads keep their order. A build with a single thread skips the readiness checks altogether.

Top module: `commit_thread_sel`

## Requirements
- R1: Status is a 3-bit code per thread: 0 idle, 1 running, 2 squashing, 3 trap pending, 4 fetch-trap pending. Only codes 0, 1 and 4 make a thread eligible. Codes 2, 3 and 5 to 7 never do.
- R2: With more than one thread, a thread is a candidate only when it is eligible, its head-ready bit is 1 and its empty bit is 0. The grant always names a candidate.
- R3: Policy code 0 (greedy) and code 3 behave exactly like code 2 (oldest-first). Code 1 selects the rotating policy.
- R4: In oldest-first mode, the candidate with the smallest head sequence number (unsigned compare) is granted.
- R5: In oldest-first mode, candidates with equal sequence numbers resolve to the lowest thread index.
- R6: In rotating mode, the list is scanned from its front and the first candidate found is granted. After reset the list holds threads 0 to N-1 in ascending order from the front.
- R7: On a clock edge where the consume input is 1, sel_valid is 1 and the policy is rotating, the granted thread moves to the tail of the list. The threads that were behind it each move up one place.
- R8: The list is left unchanged on every other clock edge: when consume is 0, when no grant is valid, or when the policy is not rotating.
- R9: When no thread qualifies, sel_valid is 0 and sel_tid is 0.
- R10: With one thread configured, thread 0 is granted exactly when its status is eligible, whatever its head-ready and empty bits.
- R11: The grant follows input changes in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Selection policy code |
| thr_status | input | 3*NTHR | Per-thread status codes, thread i at bits [3i+2:3i] |
| head_rdy | input | NTHR | Oldest instruction of thread i is ready |
| rob_empty | input | NTHR | Reorder buffer of thread i is empty |
| head_seq | input | SEQW*NTHR | Head sequence number of thread i at bits [SEQW*i +: SEQW] |
| consume | input | 1 | The current grant was used this cycle |
| sel_valid | output | 1 | A thread is granted |
| sel_tid | output | max(1,clog2(NTHR)) | Granted thread index, 0 when none |

## Verification
The assertions assume the policy input stays at one code between clock edges. They also assume consume is asserted only in cycles where a grant is on offer, and is held for at most one edge per retirement. Inputs are taken as known values once reset is released. The bench drives every input at the falling edge and pulses consume for exactly one rising edge. It sets all thread fields to defined values before reset ends. Sequence numbers are kept well below the wrap point, so the unsigned smallest-value rule is the intended age order.

// File: rtl/commit_sel_pkg.sv
// Shared encodings for the commit thread selector.
// Assumes status codes are 3 bits wide and the policy code is 2 bits wide.
package commit_sel_pkg;
    localparam int STW = 3;

    typedef enum logic [STW-1:0] {
        ST_IDLE       = 3'd0,
        ST_RUNNING    = 3'd1,
        ST_SQUASHING  = 3'd2,
        ST_TRAP_PEND  = 3'd3,
        ST_FTRAP_PEND = 3'd4
    } thr_state_e;

    typedef enum logic [1:0] {
        POL_GREEDY = 2'd0,
        POL_ROTATE = 2'd1,
        POL_OLDEST = 2'd2,
        POL_SPARE  = 2'd3
    } sel_policy_e;

    // True for the status codes that allow a thread to retire.
    function automatic logic state_allows(input logic [STW-1:0] s);
        return (s == ST_IDLE) || (s == ST_RUNNING) || (s == ST_FTRAP_PEND);
    endfunction
endpackage

// File: rtl/thread_qualify.sv
// Per-thread qualification: eligibility from status and candidacy from readiness.
// Assumes status codes follow commit_sel_pkg.
module thread_qualify
    import commit_sel_pkg::*;
#(
    parameter int NTHR = 4
) (
    input  logic [STW*NTHR-1:0] thr_status,
    input  logic [NTHR-1:0]     head_rdy,
    input  logic [NTHR-1:0]     rob_empty,
    output logic [NTHR-1:0]     elig,
    output logic [NTHR-1:0]     cand
);
    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        // Eligibility and candidacy of one thread.
        always_comb begin
            elig[i] = state_allows(thr_status[i*STW +: STW]);
            cand[i] = elig[i] && head_rdy[i] && !rob_empty[i];
        end
    end
endmodule

// File: rtl/oldest_pick.sv
// Finds the candidate with the smallest head sequence number.
// Assumes sequence numbers do not wrap between live heads; ties go to the lower index.
module oldest_pick #(
    parameter int NTHR = 4,
    parameter int SEQW = 16,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]      cand,
    input  logic [SEQW*NTHR-1:0] head_seq,
    output logic                 hit,
    output logic [TIDW-1:0]      tid
);
    logic [SEQW-1:0] best_seq;

    // Linear minimum search with strict compare to keep the lowest index on ties.
    always_comb begin
        hit      = 1'b0;
        tid      = '0;
        best_seq = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (cand[i] && (!hit || head_seq[i*SEQW +: SEQW] < best_seq)) begin
                hit      = 1'b1;
                tid      = TIDW'(i);
                best_seq = head_seq[i*SEQW +: SEQW];
            end
        end
    end
endmodule

// File: rtl/rr_order_list.sv
// Rotating priority list: scans from the front, moves a consumed winner to the tail.
// Assumes advance is only raised while hit is 1.
module rr_order_list #(
    parameter int NTHR = 4,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTHR-1:0] cand,
    input  logic            advance,
    output logic            hit,
    output logic [TIDW-1:0] tid
);
    logic [TIDW-1:0] order_q [NTHR];
    logic [TIDW-1:0] order_d [NTHR];
    logic [TIDW-1:0] pos;

    // Front-to-back scan for the first candidate in the list.
    always_comb begin
        hit = 1'b0;
        pos = '0;
        tid = '0;
        for (int p = 0; p < NTHR; p++) begin
            if (!hit && cand[order_q[p]]) begin
                hit = 1'b1;
                pos = TIDW'(p);
                tid = order_q[p];
            end
        end
    end

    // Next list: entries behind the winner move up, winner goes to the tail.
    always_comb begin
        for (int p = 0; p < NTHR - 1; p++) begin
            order_d[p] = (TIDW'(p) < pos) ? order_q[p] : order_q[p+1];
        end
        order_d[NTHR-1] = tid;
    end

    // List register, ascending at reset, updated only on a consumed grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NTHR; p++) order_q[p] <= TIDW'(p);
        end else if (advance && hit) begin
            for (int p = 0; p < NTHR; p++) order_q[p] <= order_d[p];
        end
    end

    logic [NTHR-1:0] present;
    // Which thread indices appear somewhere in the list.
    always_comb begin
        present = '0;
        for (int p = 0; p < NTHR; p++) present[order_q[p]] = 1'b1;
    end

    // R6: the list is always a permutation of all threads.
    a_r6_list_perm: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == NTHR);

    // R7: a consumed winner sits at the tail afterwards.
    a_r7_winner_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hit) |=> order_q[NTHR-1] == $past(tid));

    // R8: without an advance the front of the list holds.
    a_r8_list_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(advance && hit) |=> order_q[0] == $past(order_q[0]));
endmodule

// File: rtl/commit_thread_sel.sv
// Top of the commit thread selector: qualifies threads, runs both policies,
// and muxes the grant by policy code. Single-thread builds bypass readiness.
// Assumes policy is static between edges and consume is a one-edge pulse.
module commit_thread_sel
    import commit_sel_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int SEQW = 16,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           policy,
    input  logic [STW*NTHR-1:0]  thr_status,
    input  logic [NTHR-1:0]      head_rdy,
    input  logic [NTHR-1:0]      rob_empty,
    input  logic [SEQW*NTHR-1:0] head_seq,
    input  logic                 consume,
    output logic                 sel_valid,
    output logic [TIDW-1:0]      sel_tid
);
    logic [NTHR-1:0] elig, cand;
    logic            old_hit, rr_hit, rotate;
    logic [TIDW-1:0] old_tid, rr_tid;

    thread_qualify #(.NTHR(NTHR)) u_qual (
        .thr_status(thr_status), .head_rdy(head_rdy), .rob_empty(rob_empty),
        .elig(elig), .cand(cand)
    );

    oldest_pick #(.NTHR(NTHR), .SEQW(SEQW)) u_old (
        .cand(cand), .head_seq(head_seq), .hit(old_hit), .tid(old_tid)
    );

    rr_order_list #(.NTHR(NTHR)) u_rr (
        .clk(clk), .rst_n(rst_n), .cand(cand),
        .advance(consume && rotate), .hit(rr_hit), .tid(rr_tid)
    );

    // Policy decode: only code 1 rotates, every other code is oldest-first.
    always_comb rotate = (policy == POL_ROTATE);

    if (NTHR == 1) begin : g_single
        // One thread: grant on eligible status alone.
        always_comb begin
            sel_valid = elig[0];
            sel_tid   = '0;
        end
    end else begin : g_multi
        // Pick the result of the active policy; index forced to 0 when empty.
        always_comb begin
            sel_valid = rotate ? rr_hit : old_hit;
            sel_tid   = !sel_valid ? '0 : (rotate ? rr_tid : old_tid);
        end

        // R2: a granted thread is always a candidate.
        a_r2_grant_candidate: assert property (@(posedge clk) disable iff (!rst_n)
            sel_valid |-> cand[sel_tid]);

        // R9: no candidate means no grant.
        a_r9_none_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
            (cand == '0) |-> !sel_valid);
    end

    // R1: a granted thread has an eligible status code.
    a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> state_allows(thr_status[sel_tid*STW +: STW]));

    // R9: index reads zero whenever nothing is granted.
    a_r9_tid_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_tid == '0);
endmodule

// File: tb/sim_commit_thread_sel.sv
module sim_commit_thread_sel;
    localparam int NTHR = 4;
    localparam int SEQW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] policy = 2'd2;
    logic [3*NTHR-1:0] thr_status = '0;
    logic [NTHR-1:0] head_rdy = '0;
    logic [NTHR-1:0] rob_empty = '1;
    logic [SEQW*NTHR-1:0] head_seq = '0;
    logic consume = 1'b0;
    logic sel_valid;
    logic [1:0] sel_tid;

    logic [2:0] s1_status = 3'd0;
    logic s1_rdy = 1'b0;
    logic s1_emp = 1'b1;
    logic s1_valid;
    logic s1_tid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    commit_thread_sel #(.NTHR(NTHR), .SEQW(SEQW)) u0 (
        .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(thr_status),
        .head_rdy(head_rdy), .rob_empty(rob_empty), .head_seq(head_seq),
        .consume(consume), .sel_valid(sel_valid), .sel_tid(sel_tid)
    );

    commit_thread_sel #(.NTHR(1), .SEQW(SEQW)) u1 (
        .clk(clk), .rst_n(rst_n), .policy(2'd1), .thr_status(s1_status),
        .head_rdy(s1_rdy), .rob_empty(s1_emp), .head_seq(16'd5),
        .consume(1'b0), .sel_valid(s1_valid), .sel_tid(s1_tid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_thr(input int i, input int st, input bit rdy, input bit emp, input int seq);
        thr_status[i*3 +: 3] = 3'(st);
        head_rdy[i] = rdy;
        rob_empty[i] = emp;
        head_seq[i*SEQW +: SEQW] = SEQW'(seq);
    endtask

    task automatic expect_grant(input string req, input bit v, input int t);
        #1;
        chk(req, "sel_valid", int'(sel_valid), int'(v));
        chk(req, "sel_tid", int'(sel_tid), t);
    endtask

    task automatic pulse_consume();
        @(negedge clk) consume = 1'b1;
        @(negedge clk) consume = 1'b0;
    endtask

    task automatic all_ready();
        for (int i = 0; i < NTHR; i++) set_thr(i, 1, 1'b1, 1'b0, 10 + i);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        expect_grant("R9", 1'b0, 0);
    endtask

    task automatic t_eligibility();
        @(negedge clk) policy = 2'd2;
        set_thr(0, 2, 1'b1, 1'b0, 1);
        set_thr(1, 3, 1'b1, 1'b0, 2);
        set_thr(2, 7, 1'b1, 1'b0, 3);
        set_thr(3, 4, 1'b1, 1'b0, 9);
        expect_grant("R1", 1'b1, 3);
        set_thr(3, 0, 1'b1, 1'b0, 9);
        expect_grant("R1", 1'b1, 3);
        set_thr(3, 5, 1'b1, 1'b0, 9);
        expect_grant("R9", 1'b0, 0);
    endtask

    task automatic t_candidate();
        @(negedge clk) policy = 2'd2;
        set_thr(0, 1, 1'b0, 1'b0, 1);
        set_thr(1, 1, 1'b1, 1'b1, 2);
        set_thr(2, 1, 1'b1, 1'b0, 30);
        set_thr(3, 1, 1'b1, 1'b0, 20);
        expect_grant("R2", 1'b1, 3);
    endtask

    task automatic t_oldest();
        @(negedge clk) policy = 2'd2;
        set_thr(0, 1, 1'b1, 1'b0, 500);
        set_thr(1, 1, 1'b1, 1'b0, 40);
        set_thr(2, 4, 1'b1, 1'b0, 41);
        set_thr(3, 1, 1'b1, 1'b0, 900);
        expect_grant("R4", 1'b1, 1);
        set_thr(1, 1, 1'b1, 1'b0, 40000);
        expect_grant("R11", 1'b1, 2);
        set_thr(0, 1, 1'b1, 1'b0, 41);
        expect_grant("R5", 1'b1, 0);
        set_thr(0, 1, 1'b1, 1'b0, 70);
        set_thr(1, 1, 1'b1, 1'b0, 70);
        set_thr(2, 1, 1'b1, 1'b0, 70);
        set_thr(3, 1, 1'b1, 1'b0, 70);
        set_thr(0, 2, 1'b1, 1'b0, 70);
        expect_grant("R5", 1'b1, 1);
    endtask

    task automatic t_greedy_alias();
        @(negedge clk);
        set_thr(0, 1, 1'b1, 1'b0, 300);
        set_thr(1, 1, 1'b1, 1'b0, 200);
        set_thr(2, 1, 1'b1, 1'b0, 100);
        set_thr(3, 1, 1'b1, 1'b0, 400);
        policy = 2'd0;
        expect_grant("R3", 1'b1, 2);
        policy = 2'd3;
        expect_grant("R3", 1'b1, 2);
    endtask

    task automatic t_rotate();
        @(negedge clk) policy = 2'd1;
        all_ready();
        expect_grant("R6", 1'b1, 0);
        @(negedge clk);
        expect_grant("R8", 1'b1, 0);
        pulse_consume();            // list 1,2,3,0
        expect_grant("R7", 1'b1, 1);
        set_thr(1, 1, 1'b0, 1'b0, 0);
        set_thr(2, 1, 1'b0, 1'b0, 0);
        expect_grant("R6", 1'b1, 3);
        pulse_consume();            // list 1,2,0,3
        all_ready();
        expect_grant("R7", 1'b1, 1);
        set_thr(1, 2, 1'b1, 1'b0, 0);
        expect_grant("R6", 1'b1, 2);
        set_thr(2, 3, 1'b1, 1'b0, 0);
        expect_grant("R7", 1'b1, 0);
    endtask

    task automatic t_hold();
        @(negedge clk) policy = 2'd2;
        all_ready();
        pulse_consume();            // oldest mode: list stays 1,2,0,3
        policy = 2'd1;
        for (int i = 0; i < NTHR; i++) set_thr(i, 1, 1'b0, 1'b0, 0);
        expect_grant("R9", 1'b0, 0);
        pulse_consume();            // no grant: list stays
        all_ready();
        expect_grant("R8", 1'b1, 1);
    endtask

    task automatic t_single();
        @(negedge clk);
        s1_status = 3'd1; s1_rdy = 1'b0; s1_emp = 1'b1;
        #1;
        chk("R10", "single valid", int'(s1_valid), 1);
        chk("R10", "single tid", int'(s1_tid), 0);
        s1_status = 3'd3; s1_rdy = 1'b1; s1_emp = 1'b0;
        #1;
        chk("R10", "single valid", int'(s1_valid), 0);
        s1_status = 3'd4;
        #1;
        chk("R10", "single valid", int'(s1_valid), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_eligibility();
        t_candidate();
        t_oldest();
        t_greedy_alias();
        t_rotate();
        t_hold();
        t_single();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule